// File: doc/BRIEF.md
# Multi-Level Daisychain Bus Arbiter

This block decides which of several boards on a shared multimaster backplane owns the bus. Boards raise active-low request lines, one line per priority level, and several boards may share one line. A system-controller arbiter synchronizes the request levels. It watches the shared bus-busy line and grants the bus to the most urgent active level by driving that level's grant input. The grant then travels along a per-level daisychain of boards. A board that is not requesting passes the grant on to the next board. The first requesting board in the chain keeps the grant, asserts bus busy, negates its request and becomes master.

The arbiter issues no grant while the bus is held. It removes its grant once bus busy has been seen. If a level of higher priority than the current owner asks for the bus, the arbiter asserts bus clear. The master then finishes the transfer it is on and lets go. A master also lets go as soon as its local request drops.

The arbiter state machine has three states:
- `ARB_IDLE`: waiting. Idle-to-grant: some synchronized level is active and bus busy is negated.
- `ARB_GRANT`: driving one level's grant. Grant-to-held: bus busy is seen. Grant-to-idle: the level's request vanished first.
- `ARB_HELD`: the bus is owned. Held-to-idle: bus busy negates.

Each board requester has three states:
- `BRD_IDLE`: forwards the grant. Idle-to-wait: local request rises.
- `BRD_WAIT`: blocks the grant and drives its level's request. Wait-to-idle: local request drops. Wait-to-own: grant-in is seen while the bus is free.
- `BRD_OWN`: master. Own-to-idle: local request drops, or a transfer ends while bus clear is asserted.

Top module: `daisy_bus_arbiter`

## Requirements
- R1: After reset, all bus request lines, bus busy and bus clear are high (negated), and no level grant or local grant is active.
- R2: Level 0 has the highest priority and level LEVELS-1 the lowest. When boards on several levels request together, a board on the lowest-numbered active level becomes master.
- R3: Board 0 sits first in each level's chain. A board whose local request is low forwards grant-in to grant-out, so the lowest-numbered requesting board on the granted level wins. A board becomes master only after its level's grant was active.
- R4: At most one board is master at any time. While a board is master, bus busy is low and the master no longer drives its level's request line.
- R5: From a quiet bus, a request raised before clock edge 1 yields a local grant right after clock edge 5.
- R6: While the bus is held, a new request on the owner's level or on a lower-priority level creates no new master and leaves bus clear high.
- R7: While the bus is held, a request on a higher-priority level drives bus clear low. The master keeps the bus until its transfer-end input pulses, and the higher-priority board then becomes master.
- R8: A master keeps the bus when its transfer-end input pulses while bus clear is high. It releases the bus when its local request drops, and the next requesting board then gets the bus.
- R9: At most one level grant is active. A level grant that is active while bus busy is low is gone one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| want | input | LEVELS*BOARDS | Local bus request per board; index = level*BOARDS + chain position |
| xfer_end | input | LEVELS*BOARDS | Per-board pulse marking the end of the current transfer |
| local_gnt | output | LEVELS*BOARDS | High while that board is bus master |
| level_gnt | output | LEVELS | Grant-in driven by the arbiter into each level's chain (active high) |
| bus_req_n | output | LEVELS | Active-low request line per level (wired OR of the boards on it) |
| bus_busy_n | output | 1 | Active-low bus busy |
| bus_clear_n | output | 1 | Active-low bus clear from the arbiter |

## Verification
The bench sweeps every non-empty subset of the ten requesters, starting each time from a quiet bus. The expected master is the lowest set bit of the subset. This tells apart faults in the level order, faults in the chain order within a level, and faults in grant forwarding by idle boards. The same sweep fixes the five-edge latency. Directed sequences then hold the bus and add requests on the same level, a lower level and a higher level. They tell apart a correct clear from a spurious one, a premature handover from a proper release at the end of a transfer, and release on a dropped request from release on a transfer end.

// File: rtl/dba_pkg.sv
package dba_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_GRANT = 2'd1,
        ARB_HELD  = 2'd2
    } arb_state_t;

    typedef enum logic [1:0] {
        BRD_IDLE = 2'd0,
        BRD_WAIT = 2'd1,
        BRD_OWN  = 2'd2
    } brd_state_t;
endpackage

// File: rtl/dba_sync.sv
module dba_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dba_arbiter.sv
module dba_arbiter
    import dba_pkg::*;
#(
    parameter int LEVELS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] lvl_req,
    input  logic              busy,
    output logic [LEVELS-1:0] grant,
    output logic              clear
);
    localparam int IW = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    arb_state_t    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d, pick;
    logic          higher, clear_q;

    always_comb begin
        pick = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (lvl_req[i]) pick = IW'(i);
        end
        higher = 1'b0;
        for (int i = 0; i < LEVELS; i++) begin
            if (i < int'(owner_q) && lvl_req[i]) higher = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (|lvl_req && !busy) begin
                    state_d = ARB_GRANT;
                    owner_d = pick;
                end
            end
            ARB_GRANT: begin
                if (busy) state_d = ARB_HELD;
                else if (!lvl_req[owner_q]) state_d = ARB_IDLE;
            end
            ARB_HELD: begin
                if (!busy) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
            clear_q <= 1'b0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            clear_q <= (state_q == ARB_HELD) && busy && higher;
        end
    end

    always_comb begin
        grant = '0;
        if (state_q == ARB_GRANT) grant[owner_q] = 1'b1;
        clear = clear_q;
    end
endmodule

// File: rtl/dba_board.sv
module dba_board
    import dba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic xfer_end,
    input  logic bg_in,
    input  logic busy,
    input  logic clear,
    output logic bg_out,
    output logic req,
    output logic busy_drv,
    output logic gnt
);
    brd_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BRD_IDLE: if (want) state_d = BRD_WAIT;
            BRD_WAIT: begin
                if (!want) state_d = BRD_IDLE;
                else if (bg_in && !busy) state_d = BRD_OWN;
            end
            BRD_OWN: if (!want || (clear && xfer_end)) state_d = BRD_IDLE;
            default: state_d = BRD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BRD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bg_out   = (state_q == BRD_IDLE) ? bg_in : 1'b0;
        req      = (state_q == BRD_WAIT);
        busy_drv = (state_q == BRD_OWN);
        gnt      = (state_q == BRD_OWN);
    end
endmodule

// File: rtl/daisy_bus_arbiter.sv
module daisy_bus_arbiter #(
    parameter int LEVELS = 5,
    parameter int BOARDS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LEVELS*BOARDS-1:0] want,
    input  logic [LEVELS*BOARDS-1:0] xfer_end,
    output logic [LEVELS*BOARDS-1:0] local_gnt,
    output logic [LEVELS-1:0]        level_gnt,
    output logic [LEVELS-1:0]        bus_req_n,
    output logic                     bus_busy_n,
    output logic                     bus_clear_n
);
    localparam int NB = LEVELS * BOARDS;
    localparam int CW = BOARDS + 1;

    logic [NB-1:0]        req_vec, busy_vec;
    logic [LEVELS*CW-1:0] chain;
    logic [LEVELS-1:0]    lvl_req, lvl_req_s, lvl_gnt;
    logic                 bus_busy, clear;

    assign bus_busy = |busy_vec;

    dba_sync #(.WIDTH(LEVELS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(lvl_req), .q(lvl_req_s)
    );

    dba_arbiter #(.LEVELS(LEVELS)) u_arb (
        .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req_s), .busy(bus_busy),
        .grant(lvl_gnt), .clear(clear)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        assign chain[l*CW] = lvl_gnt[l];
        assign lvl_req[l]  = |req_vec[l*BOARDS +: BOARDS];
        for (genvar b = 0; b < BOARDS; b++) begin : g_board
            dba_board u_brd (
                .clk(clk), .rst_n(rst_n),
                .want(want[l*BOARDS+b]), .xfer_end(xfer_end[l*BOARDS+b]),
                .bg_in(chain[l*CW+b]), .busy(bus_busy), .clear(clear),
                .bg_out(chain[l*CW+b+1]), .req(req_vec[l*BOARDS+b]),
                .busy_drv(busy_vec[l*BOARDS+b]), .gnt(local_gnt[l*BOARDS+b])
            );
        end
    end

    assign level_gnt   = lvl_gnt;
    assign bus_req_n   = ~lvl_req;
    assign bus_busy_n  = ~bus_busy;
    assign bus_clear_n = ~clear;
endmodule

// File: rtl/dba_checker.sv
module dba_checker #(
    parameter int LEVELS = 5,
    parameter int NB     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEVELS-1:0] level_gnt,
    input logic [NB-1:0]     local_gnt,
    input logic              bus_busy_n
);
    p_one_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(level_gnt));

    p_one_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(local_gnt));

    p_no_grant_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|level_gnt) |-> $past(bus_busy_n));

    p_master_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|local_gnt) |-> $past(|level_gnt));

    p_grant_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|level_gnt) && !bus_busy_n) |=> !(|level_gnt));
endmodule

bind daisy_bus_arbiter dba_checker #(.LEVELS(LEVELS), .NB(LEVELS*BOARDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .level_gnt(level_gnt),
    .local_gnt(local_gnt), .bus_busy_n(bus_busy_n)
);

// File: tb/sim_daisy_bus_arbiter.sv
module sim_daisy_bus_arbiter;
    localparam int L  = 5;
    localparam int B  = 2;
    localparam int NB = L * B;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] want = '0;
    logic [NB-1:0] xfer_end = '0;
    logic [NB-1:0] local_gnt;
    logic [L-1:0]  level_gnt, bus_req_n;
    logic          bus_busy_n, bus_clear_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    daisy_bus_arbiter #(.LEVELS(L), .BOARDS(B)) u0 (
        .clk(clk), .rst_n(rst_n), .want(want), .xfer_end(xfer_end),
        .local_gnt(local_gnt), .level_gnt(level_gnt), .bus_req_n(bus_req_n),
        .bus_busy_n(bus_busy_n), .bus_clear_n(bus_clear_n)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_grant(output int lat);
        lat = 0;
        while (local_gnt == '0 && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        want = '0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_req_n == '1, "R1 req lines", bus_req_n, '1);
        check(bus_busy_n == 1'b1 && bus_clear_n == 1'b1, "R1 busy/clear",
              {bus_busy_n, bus_clear_n}, 2'b11);
        check(local_gnt == '0 && level_gnt == '0, "R1 grants",
              {level_gnt, local_gnt}, 0);

        // Exhaustive sweep: expected master is the lowest set request bit
        for (int s = 1; s < (1 << NB); s++) begin
            int win = 0;
            for (int k = NB - 1; k >= 0; k--) if (s[k]) win = k;
            want = NB'(s);
            wait_grant(lat);
            check(lat == 5, "R5 latency", lat, 5);
            check(local_gnt == NB'(1 << win), "R2 R3 winner", local_gnt, 1 << win);
            check(bus_busy_n == 1'b0, "R4 busy low", bus_busy_n, 0);
            quiet();
        end

        // Higher level preempts via bus clear at the end of a transfer
        want[7] = 1'b1;                     // level 3, position 1
        wait_grant(lat);
        check(local_gnt == NB'(1 << 7), "R3 pass-through", local_gnt, 1 << 7);
        repeat (3) @(negedge clk);
        check(bus_req_n[3] == 1'b1, "R4 master negates request", bus_req_n[3], 1);
        want[2] = 1'b1;                     // level 1, position 0
        repeat (6) @(negedge clk);
        check(bus_clear_n == 1'b0, "R7 clear asserted", bus_clear_n, 0);
        check(local_gnt == NB'(1 << 7), "R7 master holds", local_gnt, 1 << 7);
        xfer_end[7] = 1'b1;
        @(negedge clk);
        xfer_end[7] = 1'b0;
        lat = 0;
        while (local_gnt != NB'(1 << 2) && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(local_gnt == NB'(1 << 2), "R7 handover", local_gnt, 1 << 2);
        quiet();

        // Same and lower level requests while held: no clear, no new master
        want[2] = 1'b1;
        wait_grant(lat);
        want[3] = 1'b1;
        want[8] = 1'b1;
        repeat (8) @(negedge clk);
        check(bus_clear_n == 1'b1, "R6 no clear", bus_clear_n, 1);
        check(local_gnt == NB'(1 << 2), "R6 no new master", local_gnt, 1 << 2);
        xfer_end[2] = 1'b1;
        @(negedge clk);
        xfer_end[2] = 1'b0;
        repeat (4) @(negedge clk);
        check(local_gnt == NB'(1 << 2), "R8 xfer_end ignored", local_gnt, 1 << 2);
        check(bus_busy_n == 1'b0, "R8 busy held", bus_busy_n, 0);
        want[2] = 1'b0;
        lat = 0;
        while (local_gnt != NB'(1 << 3) && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(local_gnt == NB'(1 << 3), "R8 release to next", local_gnt, 1 << 3);
        quiet();
        check(bus_busy_n == 1'b1 && local_gnt == '0, "R8 idle after drop",
              {bus_busy_n, local_gnt}, 1 << NB);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule